// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block turns a serial line into parallel words. The line idles high. A frame is a low start bit, then 7, 8 or 9 data bits with the least significant bit first. An optional parity bit and one or two high stop bits follow. The receiver divides the system clock by a programmable amount to make a tick at 16 times the bit rate. It confirms the start bit halfway through that bit and then samples every later bit at its centre. When the frame ends, the assembled word goes into a holding buffer. A one-cycle interrupt pulse marks the moment the word lands there.

Three error flags come with the buffered word:
- **Framing** is set when a stop bit is sampled low.
- **Parity** is set when the parity check fails.
- **Overrun** is set when the previous word was still unread as the next frame neared its end.

A fourth output, the error summary, is the OR of the three flags. Software takes a word with a one-cycle read strobe. Dropping the enable stops reception and wipes the three error flags.

The controller is a state machine with five states:
- **IDLE** waits for a low line. It moves to START when the enable is high and the line is low.
- **START** counts eight ticks. It then samples the line: low moves to DATA, high returns to IDLE as a false start.
- **DATA** takes one bit every sixteen ticks. After the last data bit it moves to PARITY if parity is enabled, otherwise to STOP.
- **PARITY** takes one bit and moves to STOP.
- **STOP** takes one or two stop bits. After the final one it returns to IDLE and, in that same cycle, transfers the word into the buffer.

From any state, a low enable forces IDLE.

Top module: `uart_rx_core`

## Requirements
- R1: While `rx_en` is 0, line activity is ignored: no `rx_irq` pulse occurs and `rx_full` keeps its value.
- R2: A start is accepted only if the line is still low on the eighth tick after the falling edge is seen. A low pulse shorter than that returns the machine to IDLE and nothing is received.
- R3: `data_len` selects the data width: 00 gives 7 bits, 01 gives 8 bits, 10 gives 9 bits. Bits arrive least significant first and are right-justified in `rx_data`, with unused upper bits 0. `par_en` adds a parity bit after the data and `two_stop` selects two stop bits instead of one.
- R4: One bit period lasts 16 × (`baud_div` + 1) clock cycles, and every bit is sampled near its centre.
- R5: At the end of the last stop bit's sample, `rx_data` is loaded, `rx_full` becomes 1 and `rx_irq` is high for exactly that one cycle.
- R6: A `rd_strobe` cycle clears `rx_full`. If a transfer happens in the same cycle, the transfer wins and `rx_full` stays 1.
- R7: `ovr_err` becomes 1 when `rx_full` is 1 and `rd_strobe` is 0 at the sampling of the bit just before the last stop bit. This happens before the word is transferred. The flag stays set until reception is disabled, and the word buffered in that frame is not defined.
- R8: At each transfer, `frm_err` is loaded with 1 if any configured stop bit was sampled low, and with 0 otherwise.
- R9: At each transfer, `par_err` is loaded with 1 if `par_en` is 1 and the count of ones in the data and parity bits is wrong for the mode. With `par_odd` = 0 the count must be even; with `par_odd` = 1 it must be odd. `par_err` is loaded with 0 when parity is disabled.
- R10: `err_sum` equals the OR of `ovr_err`, `frm_err` and `par_err`.
- R11: A cycle with `rx_en` at 0 clears `ovr_err`, `frm_err` and `par_err` at the next clock edge. `rx_full` and `rx_data` are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| rx_en | input | 1 | Reception enable |
| baud_div | input | 8 | Divider value n; a tick occurs every n+1 clocks |
| data_len | input | 2 | Data width select (00: 7, 01: 8, 10: 9) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| two_stop | input | 1 | 1: two stop bits, 0: one |
| rxd | input | 1 | Serial input line, idle high |
| rd_strobe | input | 1 | One-cycle read of the buffered word |
| rx_data | output | 9 | Buffered received word, right-justified |
| rx_full | output | 1 | Buffer holds an unread word |
| ovr_err | output | 1 | Overrun flag |
| frm_err | output | 1 | Framing error flag |
| par_err | output | 1 | Parity error flag |
| err_sum | output | 1 | OR of the three error flags |
| rx_irq | output | 1 | One-cycle pulse on transfer into the buffer |

## Verification
Two events can share a clock edge: the read strobe clearing the buffer-full status, and the transfer of a new word setting it. The bench starts a frame while the buffer already holds an unread word. It holds the read strobe high throughout the frame and releases it on the falling edge where the interrupt pulse is first seen, so the read and the transfer share the same rising edge. It then requires the buffer to stay full with the new word and no overrun to be raised, because the strobe was active at the overrun sampling point. Separately, frames sent against an unread buffer must show the overrun flag a quarter bit into the last stop bit, while the interrupt count has not yet moved.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;

    localparam int OS_RATE = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_t;

endpackage

// File: rtl/uart_rx_sync.sv
`timescale 1ns/1ps
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_baud.sv
`timescale 1ns/1ps
module uart_rx_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || cnt == div) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = !clr && (cnt == div);
endmodule

// File: rtl/uart_rx_fsm.sv
`timescale 1ns/1ps
module uart_rx_fsm
    import uart_rx_pkg::*;
#(
    parameter int MAX_BITS = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_en,
    input  logic                tick,
    input  logic                rxd,
    input  logic [1:0]          data_len,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic                two_stop,
    input  logic                rd_strobe,
    output logic                baud_clr,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_full,
    output logic                ovr_err,
    output logic                frm_err,
    output logic                par_err,
    output logic                rx_irq
);
    localparam int CNT_W = $clog2(MAX_BITS + 1);
    localparam int OS_W  = $clog2(OS_RATE);
    localparam logic [OS_W-1:0] OS_MID  = OS_W'(OS_RATE / 2 - 1);
    localparam logic [OS_W-1:0] OS_LAST = OS_W'(OS_RATE - 1);

    rx_state_t state, state_nx;

    logic [OS_W-1:0]     os_cnt;
    logic [CNT_W-1:0]    bit_cnt;
    logic [CNT_W-1:0]    nbits;
    logic [MAX_BITS-1:0] shreg;
    logic                par_acc;
    logic                frm_seen;
    logic                stop_idx;

    logic sample, start_ok, start_bad, last_data, last_stop;
    logic done, penult, ovr_hit;

    always_comb begin
        unique case (data_len)
            2'b00:   nbits = CNT_W'(MAX_BITS - 2);
            2'b10:   nbits = CNT_W'(MAX_BITS);
            default: nbits = CNT_W'(MAX_BITS - 1);
        endcase
    end

    assign sample    = tick && (os_cnt == OS_LAST);
    assign start_ok  = (state == ST_START) && tick && (os_cnt == OS_MID) && !rxd;
    assign start_bad = (state == ST_START) && tick && (os_cnt == OS_MID) && rxd;
    assign last_data = (bit_cnt == nbits - 1'b1);
    assign last_stop = (stop_idx == two_stop);
    assign done      = rx_en && (state == ST_STOP) && sample && last_stop;

    always_comb begin
        if (two_stop) begin
            penult = (state == ST_STOP) && sample && !stop_idx;
        end else if (par_en) begin
            penult = (state == ST_PARITY) && sample;
        end else begin
            penult = (state == ST_DATA) && sample && last_data;
        end
    end

    assign ovr_hit  = rx_en && penult && rx_full && !rd_strobe;
    assign baud_clr = (state == ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (rx_en && !rxd) state_nx = ST_START;
            end
            ST_START: begin
                if (start_ok)       state_nx = ST_DATA;
                else if (start_bad) state_nx = ST_IDLE;
            end
            ST_DATA: begin
                if (sample && last_data) state_nx = par_en ? ST_PARITY : ST_STOP;
            end
            ST_PARITY: begin
                if (sample) state_nx = ST_STOP;
            end
            ST_STOP: begin
                if (sample && last_stop) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
        if (!rx_en) state_nx = ST_IDLE;
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_cnt   <= '0;
            bit_cnt  <= '0;
            shreg    <= '0;
            par_acc  <= 1'b0;
            frm_seen <= 1'b0;
            stop_idx <= 1'b0;
        end else begin
            if (state == ST_IDLE) begin
                os_cnt <= '0;
            end else if (state == ST_START) begin
                if (tick) os_cnt <= (os_cnt == OS_MID) ? '0 : os_cnt + 1'b1;
            end else if (tick) begin
                os_cnt <= os_cnt + 1'b1;
            end

            if (start_ok) begin
                bit_cnt  <= '0;
                par_acc  <= 1'b0;
                frm_seen <= 1'b0;
                stop_idx <= 1'b0;
            end
            if (state == ST_DATA && sample) begin
                shreg   <= {rxd, shreg[MAX_BITS-1:1]};
                bit_cnt <= bit_cnt + 1'b1;
                par_acc <= par_acc ^ rxd;
            end
            if (state == ST_PARITY && sample) begin
                par_acc <= par_acc ^ rxd;
            end
            if (state == ST_STOP && sample) begin
                stop_idx <= 1'b1;
                if (!rxd) frm_seen <= 1'b1;
            end
        end
    end

    // buffer, flags and interrupt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_full <= 1'b0;
            ovr_err <= 1'b0;
            frm_err <= 1'b0;
            par_err <= 1'b0;
            rx_irq  <= 1'b0;
        end else begin
            rx_irq <= 1'b0;
            if (!rx_en) begin
                ovr_err <= 1'b0;
                frm_err <= 1'b0;
                par_err <= 1'b0;
            end else begin
                if (ovr_hit) ovr_err <= 1'b1;
                if (done) begin
                    rx_data <= shreg >> (CNT_W'(MAX_BITS) - nbits);
                    frm_err <= frm_seen | !rxd;
                    par_err <= par_en & (par_acc ^ par_odd);
                    rx_irq  <= 1'b1;
                end
            end
            if (done)           rx_full <= 1'b1;
            else if (rd_strobe) rx_full <= 1'b0;
        end
    end

    p_idle_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (state == ST_IDLE));

    p_false_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_bad |=> (state == ST_IDLE));

    p_irq_sets_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_full);

    p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

    p_ovr_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_err) |-> $past(rx_full) && !$past(rd_strobe));

    p_frm_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && $past(rx_en) && !rx_irq) |-> $stable(frm_err));

    p_par_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && $past(rx_en) && !rx_irq) |-> $stable(par_err));

    p_flags_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !ovr_err && !frm_err && !par_err);
endmodule

// File: rtl/uart_rx_core.sv
`timescale 1ns/1ps
module uart_rx_core #(
    parameter int DIV_W    = 8,
    parameter int MAX_BITS = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_en,
    input  logic [DIV_W-1:0]    baud_div,
    input  logic [1:0]          data_len,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic                two_stop,
    input  logic                rxd,
    input  logic                rd_strobe,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_full,
    output logic                ovr_err,
    output logic                frm_err,
    output logic                par_err,
    output logic                err_sum,
    output logic                rx_irq
);
    logic rxd_s;
    logic tick;
    logic baud_clr;

    uart_rx_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rxd),
        .q     (rxd_s)
    );

    uart_rx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (baud_clr),
        .div   (baud_div),
        .tick  (tick)
    );

    uart_rx_fsm #(.MAX_BITS(MAX_BITS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .tick      (tick),
        .rxd       (rxd_s),
        .data_len  (data_len),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .two_stop  (two_stop),
        .rd_strobe (rd_strobe),
        .baud_clr  (baud_clr),
        .rx_data   (rx_data),
        .rx_full   (rx_full),
        .ovr_err   (ovr_err),
        .frm_err   (frm_err),
        .par_err   (par_err),
        .rx_irq    (rx_irq)
    );

    assign err_sum = ovr_err | frm_err | par_err;

    p_sum_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frm_err) |-> err_sum);
endmodule

// File: tb/uart_rx_core_test.sv
`timescale 1ns/1ps
module uart_rx_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic [7:0] baud_div = 8'd0;
    logic [1:0] data_len = 2'b01;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic       rxd = 1'b1;
    logic       rd_strobe = 1'b0;
    logic [8:0] rx_data;
    logic       rx_full, ovr_err, frm_err, par_err, err_sum, rx_irq;

    int nvec = 0;
    int nfail = 0;
    int irq_cnt = 0;
    int irq_mark = 0;

    logic       m_full = 1'b0;
    logic       m_ovr = 1'b0;
    logic       m_frm = 1'b0;
    logic       m_par = 1'b0;
    logic [8:0] m_data = 9'd0;

    always #2.5 clk = ~clk;

    uart_rx_core uut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .baud_div(baud_div),
        .data_len(data_len), .par_en(par_en), .par_odd(par_odd),
        .two_stop(two_stop), .rxd(rxd), .rd_strobe(rd_strobe),
        .rx_data(rx_data), .rx_full(rx_full), .ovr_err(ovr_err),
        .frm_err(frm_err), .par_err(par_err), .err_sum(err_sum),
        .rx_irq(rx_irq)
    );

    always @(negedge clk) if (rst_n && rx_irq) irq_cnt++;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int nbits_of(input logic [1:0] sel);
        return (sel == 2'b00) ? 7 : (sel == 2'b10) ? 9 : 8;
    endfunction

    function automatic logic [8:0] mask_of(input logic [8:0] d, input logic [1:0] sel);
        return d & 9'((1 << nbits_of(sel)) - 1);
    endfunction

    function automatic logic parity_bit(input logic [8:0] dm, input logic odd);
        return odd ? ~(^dm) : (^dm);
    endfunction

    task automatic pulse_read();
        rd_strobe = 1'b1;
        wait_clks(1);
        rd_strobe = 1'b0;
        m_full = 1'b0;
    endtask

    task automatic drive_frame(input logic [8:0] d, input bit bad_par, input bit bad_s1,
                               input bit bad_s2, input bit mid_chk);
        int bp;
        logic [8:0] dm;
        bp = 16 * (int'(baud_div) + 1);
        dm = mask_of(d, data_len);
        rxd = 1'b0;
        wait_clks(bp);
        for (int i = 0; i < nbits_of(data_len); i++) begin
            rxd = dm[i];
            wait_clks(bp);
        end
        if (par_en) begin
            rxd = parity_bit(dm, par_odd) ^ bad_par;
            wait_clks(bp);
        end
        if (two_stop) begin
            rxd = ~bad_s1;
            wait_clks(bp);
            rxd = ~bad_s2;
        end else begin
            rxd = ~bad_s1;
        end
        wait_clks(4 * (int'(baud_div) + 1));
        if (mid_chk) begin
            chk("R7 overrun flag before transfer", 32'(ovr_err), 32'(m_ovr));
            chk("R7 R5 transfer not yet done", 32'(irq_cnt), 32'(irq_mark));
        end
        wait_clks(12 * (int'(baud_div) + 1));
        rxd = 1'b1;
        wait_clks(2 * bp);
    endtask

    task automatic send_frame(input logic [8:0] d, input bit bad_par, input bit bad_s1,
                              input bit bad_s2);
        logic full_prev;
        full_prev = m_full;
        if (full_prev) m_ovr = 1'b1;
        irq_mark = irq_cnt;
        drive_frame(d, bad_par, bad_s1, bad_s2, 1'b1);
        m_full = 1'b1;
        m_frm  = bad_s1 | (two_stop & bad_s2);
        m_par  = par_en & bad_par;
        m_data = mask_of(d, data_len);
        if (!full_prev) chk("R3 R4 received word", 32'(rx_data), 32'(m_data));
        chk("R5 buffer full after transfer", 32'(rx_full), 32'(m_full));
        chk("R5 one interrupt per word", 32'(irq_cnt), 32'(irq_mark + 1));
        chk("R8 framing flag", 32'(frm_err), 32'(m_frm));
        chk("R9 parity flag", 32'(par_err), 32'(m_par));
        chk("R7 overrun flag", 32'(ovr_err), 32'(m_ovr));
        chk("R10 error summary", 32'(err_sum), 32'(m_ovr | m_frm | m_par));
    endtask

    task automatic disable_pulse();
        rx_en = 1'b0;
        wait_clks(2);
        m_ovr = 1'b0; m_frm = 1'b0; m_par = 1'b0;
        chk("R11 flags cleared", 32'({ovr_err, frm_err, par_err}), 32'(0));
        chk("R11 full kept", 32'(rx_full), 32'(m_full));
        chk("R11 data kept", 32'(rx_data), 32'(m_data));
        rx_en = 1'b1;
        wait_clks(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        wait_clks(4);
        rst_n = 1'b1;
        wait_clks(2);
        chk("R5 reset buffer empty", 32'(rx_full), 32'(0));
        chk("R10 reset flags clear", 32'({ovr_err, frm_err, par_err, err_sum}), 32'(0));
        chk("R5 reset no interrupt", 32'(irq_cnt), 32'(0));

        // R1: disabled receiver ignores a full frame
        baud_div = 8'd1;
        irq_mark = irq_cnt;
        drive_frame(9'h0A5, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R1 no interrupt while disabled", 32'(irq_cnt), 32'(irq_mark));
        chk("R1 buffer untouched while disabled", 32'(rx_full), 32'(0));
        rx_en = 1'b1;
        wait_clks(2);

        // R2: low pulse shorter than half a bit is rejected
        rxd = 1'b0;
        wait_clks(3 * (int'(baud_div) + 1));
        rxd = 1'b1;
        wait_clks(40 * (int'(baud_div) + 1));
        chk("R2 glitch gives no interrupt", 32'(irq_cnt), 32'(irq_mark));
        chk("R2 glitch leaves buffer empty", 32'(rx_full), 32'(0));

        // directed formats
        data_len = 2'b10; par_en = 1'b1; par_odd = 1'b1; two_stop = 1'b1;
        send_frame(9'h1FF, 1'b0, 1'b0, 1'b0);
        pulse_read();
        chk("R6 read clears full", 32'(rx_full), 32'(0));
        data_len = 2'b00; par_en = 1'b1; par_odd = 1'b0; two_stop = 1'b0; baud_div = 8'd0;
        send_frame(9'h000, 1'b1, 1'b0, 1'b0);
        pulse_read();
        data_len = 2'b01; par_en = 1'b0; two_stop = 1'b1; baud_div = 8'd2;
        send_frame(9'h03C, 1'b0, 1'b1, 1'b0);
        // second unread frame: overrun
        send_frame(9'h0C3, 1'b0, 1'b0, 1'b0);
        disable_pulse();

        // R6: read and transfer on the same edge; buffer already full
        data_len = 2'b01; par_en = 1'b1; par_odd = 1'b0; two_stop = 1'b0; baud_div = 8'd1;
        irq_mark = irq_cnt;
        fork
            drive_frame(9'h05A, 1'b0, 1'b0, 1'b0, 1'b0);
            begin
                rd_strobe = 1'b1;
                do @(negedge clk); while (!rx_irq);
                rd_strobe = 1'b0;
            end
        join
        m_full = 1'b1; m_data = 9'h05A;
        chk("R6 transfer wins over read", 32'(rx_full), 32'(1));
        chk("R6 word after collision", 32'(rx_data), 32'(9'h05A));
        chk("R7 no overrun while reading", 32'(ovr_err), 32'(0));
        chk("R5 collision interrupt", 32'(irq_cnt), 32'(irq_mark + 1));

        // constrained random frames
        for (int k = 0; k < 40; k++) begin
            logic [8:0] d;
            bit bp, b1, b2;
            if ($urandom % 2 == 0) pulse_read();
            if ($urandom % 6 == 0) disable_pulse();
            baud_div = 8'($urandom % 3);
            data_len = 2'($urandom % 3);
            par_en   = 1'($urandom % 2);
            par_odd  = 1'($urandom % 2);
            two_stop = 1'($urandom % 2);
            d  = 9'($urandom);
            bp = par_en && ($urandom % 5 == 0);
            b1 = ($urandom % 6 == 0);
            b2 = two_stop && ($urandom % 6 == 0);
            send_frame(d, bp, b1, b2);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule